// File: doc/BRIEF.md
# Parallel PHY Control-Port Register Target

This block is the PHY-side end of a strobe-driven configuration port. A host-side sequencer puts a value on a 16-bit input bus and pulses one of four level strobes. One strobe loads that value as the register address, one loads it as pending write data, one commits the pending data to the addressed register, and one copies the addressed register onto a 16-bit output bus. Each strobe level is answered by a single acknowledge line. The acknowledge rises a fixed number of cycles after the strobe rises and falls the same number of cycles after the strobe falls. This gives a host sequencer a cycle-exact partner in simulation and in FPGA bring-up, with no analog PHY behind it.

Three register groups are decoded. The first is eight general scratch words. The second is a clock/reset word, and writing a 1 to its bit 0 starts an internal reset. That write is never acknowledged, and the block ignores every strobe for a parameterized number of cycles. The third is a read-only lane status word whose PLL-locked bit stays clear for a further parameterized lock time after the reset window ends, then sets. Every other address reads as zero.

Top module: `phyr_ctl_responder`

## Requirements
- R1: After the synchronous reset input is released, ack_o is 0, dout_o is 0, and the lane status word reads 0 (PLL-locked bit clear).
- R2: ack_o goes to 1 exactly ACK_LAT cycles after an accepted strobe is first sampled high. It returns to 0 exactly ACK_LAT cycles after all strobes are first sampled low. It is never high once all strobes have been low for ACK_LAT cycles.
- R3: A rising capture-address strobe loads din_i as the current address. A rising capture-data strobe loads din_i as pending data. A rising write strobe stores the pending data in the addressed register. A rising read strobe loads dout_o with the addressed register, and dout_o keeps that value until the next accepted read or an internal reset.
- R4: Addresses 0x0010 to 0x0017 select eight independent 16-bit scratch words, indexed by the low three address bits.
- R5: Reads of any undecoded address return 0. Writes to an undecoded address are acknowledged, change no register, and do not alias onto a scratch word.
- R6: A write to the clock/reset word (address 0x7F3F) with bit 0 clear is acknowledged and stored, and a later read of 0x7F3F returns the stored value.
- R7: A write to 0x7F3F with bit 0 set produces no acknowledge and starts an internal reset that lasts RST_CYC cycles. After that window the block answers strobes again.
- R8: During the internal reset window every strobe is ignored: no acknowledge, no address or data capture, and no register update.
- R9: The lane status word (address 0x2003) reads 0 except for bit 1, which is the PLL-locked flag. The flag is clear during the reset window and for LOCK_CYC cycles after it, and then sets. Writes to 0x2003 have no effect.
- R10: An internal reset clears the current address, the pending data, the clock/reset word and dout_o, and leaves the scratch words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_addr_i | input | 1 | Capture-address strobe (level) |
| cap_data_i | input | 1 | Capture-data strobe (level) |
| wr_i | input | 1 | Write-commit strobe (level) |
| rd_i | input | 1 | Read strobe (level) |
| din_i | input | 16 | Address or data supplied with a capture strobe |
| ack_o | output | 1 | Acknowledge, follows the strobe level after ACK_LAT cycles |
| dout_o | output | 16 | Value of the last register read |

## Verification
A wrong address or pending-data latch appears at the ports on the next read, as a wrong dout_o value one handshake later. A wrong acknowledge pipeline shows up at once as an edge one cycle early or late against ACK_LAT. A reset sequencer in the wrong state shows either as an acknowledge during the reset window, within ACK_LAT cycles of the ignored strobe, or as a lane status word whose lock bit is already set on the first read after the window, or still clear after LOCK_CYC. A reset that clears too much or too little is caught by reading the scratch and clock/reset words and the unaddressed read right after the window ends.

// File: rtl/phyr_pkg.sv
package phyr_pkg;
  localparam int NSTB     = 4;
  localparam int STB_ADDR = 0;
  localparam int STB_DATA = 1;
  localparam int STB_WR   = 2;
  localparam int STB_RD   = 3;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_RESET,
    SQ_LOCK,
    SQ_READY
  } seq_t;
endpackage

// File: rtl/phyr_edge.sv
module phyr_edge #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic         any_hi
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) prev_q[i] <= 1'b0;
      else     prev_q[i] <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~prev_q[i];
  end

  assign any_hi = |lvl;
endmodule

// File: rtl/phyr_ack_pipe.sv
module phyr_ack_pipe #(
  parameter int LAT = 2
) (
  input  logic clk,
  input  logic flush,
  input  logic d,
  output logic q
);
  logic [LAT-1:0] sh_q;

  if (LAT == 1) begin : g_one
    always_ff @(posedge clk) begin
      if (flush) sh_q <= '0;
      else       sh_q <= d;
    end
  end else begin : g_many
    always_ff @(posedge clk) begin
      if (flush) sh_q <= '0;
      else       sh_q <= {sh_q[LAT-2:0], d};
    end
  end

  assign q = sh_q[LAT-1];
endmodule

// File: rtl/phyr_rf.sv
module phyr_rf #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    rdata <= mem[idx];
  end
endmodule

// File: rtl/phyr_rst_seq.sv
module phyr_rst_seq
  import phyr_pkg::*;
#(
  parameter int RST_CYC  = 20,
  parameter int LOCK_CYC = 40,
  localparam int MAXC    = (RST_CYC > LOCK_CYC) ? RST_CYC : LOCK_CYC,
  localparam int CW      = $clog2(MAXC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic locked
);
  seq_t          st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else if (start) begin
      st_q  <= SQ_RESET;
      cnt_q <= CW'(RST_CYC - 1);
    end else begin
      case (st_q)
        SQ_RESET: begin
          if (cnt_q == '0) begin
            st_q  <= SQ_LOCK;
            cnt_q <= CW'(LOCK_CYC - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        SQ_LOCK: begin
          if (cnt_q == '0) st_q <= SQ_READY;
          else             cnt_q <= cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign busy   = (st_q == SQ_RESET);
  assign locked = (st_q == SQ_READY);
endmodule

// File: rtl/phyr_ctl_responder.sv
module phyr_ctl_responder
  import phyr_pkg::*;
#(
  parameter int            DW          = 16,
  parameter int            RF_DEPTH    = 8,
  parameter logic [DW-1:0] RF_BASE     = 16'h0010,
  parameter logic [DW-1:0] CLKRST_ADDR = 16'h7F3F,
  parameter logic [DW-1:0] LANE_ADDR   = 16'h2003,
  parameter int            PLL_BIT     = 1,
  parameter int            ACK_LAT     = 2,
  parameter int            RST_CYC     = 20,
  parameter int            LOCK_CYC    = 40,
  localparam int           IW          = $clog2(RF_DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_addr_i,
  input  logic          cap_data_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] din_i,
  output logic          ack_o,
  output logic [DW-1:0] dout_o
);
  logic [NSTB-1:0] stb_lvl, stb_rise, stb_acc;
  logic            stb_any;
  logic            busy, pll_locked, rst_entry, rd_take;
  logic [DW-1:0]   addr_q, pend_q, clkrst_q, dout_q;
  logic [DW-1:0]   rf_q, lane_val, rd_val;
  logic            hit_rf, rf_we, req_q, req_next;

  assign stb_lvl = {rd_i, wr_i, cap_data_i, cap_addr_i};

  phyr_edge #(.N(NSTB)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl    (stb_lvl),
    .rise   (stb_rise),
    .any_hi (stb_any)
  );

  assign stb_acc   = stb_rise & {NSTB{~busy}};
  assign rd_take   = stb_acc[STB_RD];
  assign hit_rf    = (addr_q[DW-1:IW] == RF_BASE[DW-1:IW]);
  assign rst_entry = stb_acc[STB_WR] && (addr_q == CLKRST_ADDR) && pend_q[0];
  assign rf_we     = stb_acc[STB_WR] && hit_rf;

  phyr_rst_seq #(.RST_CYC(RST_CYC), .LOCK_CYC(LOCK_CYC)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (rst_entry),
    .busy   (busy),
    .locked (pll_locked)
  );

  phyr_rf #(.DW(DW), .DEPTH(RF_DEPTH)) u_rf (
    .clk   (clk),
    .we    (rf_we),
    .idx   (addr_q[IW-1:0]),
    .wdata (pend_q),
    .rdata (rf_q)
  );

  always_comb begin
    lane_val          = '0;
    lane_val[PLL_BIT] = pll_locked;
  end

  always_comb begin
    if (hit_rf)                    rd_val = rf_q;
    else if (addr_q == CLKRST_ADDR) rd_val = clkrst_q;
    else if (addr_q == LANE_ADDR)   rd_val = lane_val;
    else                           rd_val = '0;
  end

  always_ff @(posedge clk) begin
    if (rst || rst_entry) begin
      addr_q   <= '0;
      pend_q   <= '0;
      clkrst_q <= '0;
      dout_q   <= '0;
    end else begin
      if (stb_acc[STB_ADDR]) addr_q <= din_i;
      if (stb_acc[STB_DATA]) pend_q <= din_i;
      if (stb_acc[STB_WR] && (addr_q == CLKRST_ADDR)) clkrst_q <= pend_q;
      if (rd_take) dout_q <= rd_val;
    end
  end

  always_comb begin
    if (busy || rst_entry) req_next = 1'b0;
    else if (|stb_acc)     req_next = 1'b1;
    else if (!stb_any)     req_next = 1'b0;
    else                   req_next = req_q;
  end

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= req_next;
  end

  phyr_ack_pipe #(.LAT(ACK_LAT)) u_ack (
    .clk   (clk),
    .flush (rst || busy),
    .d     (req_next),
    .q     (ack_o)
  );

  assign dout_o = dout_q;
endmodule

// File: rtl/phyr_ctl_responder_chk.sv
module phyr_ctl_responder_chk #(
  parameter int DW      = 16,
  parameter int ACK_LAT = 2,
  localparam int QW     = $clog2(ACK_LAT + 1) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic [3:0]    strobes,
  input logic          ack,
  input logic [DW-1:0] dout,
  input logic          busy,
  input logic          locked,
  input logic          rst_entry,
  input logic          rd_take
);
  logic [QW-1:0] quiet_q;

  always_ff @(posedge clk) begin
    if (rst)                          quiet_q <= '0;
    else if (|strobes)                quiet_q <= '0;
    else if (quiet_q < QW'(ACK_LAT))  quiet_q <= quiet_q + 1'b1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!ack && dout == '0));

  // R2
  ack_release_chk: assert property (@(posedge clk) disable iff (rst)
    (quiet_q >= QW'(ACK_LAT)) |-> !ack);

  // R3
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_take && !rst_entry) |=> $stable(dout));

  // R7
  reset_enter_chk: assert property (@(posedge clk) disable iff (rst)
    rst_entry |=> busy);

  // R8
  quiet_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> !ack);

  // R9
  unlocked_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !locked);
endmodule

bind phyr_ctl_responder phyr_ctl_responder_chk #(.DW(DW), .ACK_LAT(ACK_LAT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .strobes   (stb_lvl),
  .ack       (ack_o),
  .dout      (dout_o),
  .busy      (busy),
  .locked    (pll_locked),
  .rst_entry (rst_entry),
  .rd_take   (rd_take)
);

// File: tb/tb_phyr_ctl_responder.sv
`timescale 1ns/1ps
module tb_phyr_ctl_responder;
  localparam int LAT   = 2;
  localparam int RSTC  = 20;
  localparam int LOCKC = 40;
  localparam int SA = 0, SD = 1, SW = 2, SR = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  stb = '0;
  logic [15:0] din = '0;
  logic        ack;
  logic [15:0] dout;
  int          checks = 0;
  int          fails  = 0;
  int          cyc    = 0;

  always #2.5 clk = ~clk;

  phyr_ctl_responder #(.ACK_LAT(LAT), .RST_CYC(RSTC), .LOCK_CYC(LOCKC)) dut (
    .clk        (clk),
    .rst        (rst),
    .cap_addr_i (stb[SA]),
    .cap_data_i (stb[SD]),
    .wr_i       (stb[SW]),
    .rd_i       (stb[SR]),
    .din_i      (din),
    .ack_o      (ack),
    .dout_o     (dout)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= 50000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<50000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one strobe handshake with cycle-exact acknowledge checks (R2)
  task automatic strobe(input int which, input logic [15:0] val, input logic exp_ack, input string tag);
    @(negedge clk);
    din = val;
    stb[which] = 1'b1;
    for (int j = 1; j <= LAT; j++) begin
      @(negedge clk);
      chk({tag, " R2 ack rise"}, 16'(ack), (j == LAT) ? 16'(exp_ack) : 16'h0);
    end
    stb[which] = 1'b0;
    for (int j = 1; j <= LAT; j++) begin
      @(negedge clk);
      chk({tag, " R2 ack fall"}, 16'(ack), (j == LAT) ? 16'h0 : 16'(exp_ack));
    end
  endtask

  task automatic wr_reg(input logic [15:0] a, input logic [15:0] d, input string tag);
    strobe(SA, a, 1'b1, tag);
    strobe(SD, d, 1'b1, tag);
    strobe(SW, 16'h0, 1'b1, tag);
  endtask

  task automatic rd_reg(input logic [15:0] a, input logic [15:0] exp, input string tag);
    strobe(SA, a, 1'b1, tag);
    strobe(SR, 16'h0, 1'b1, tag);
    chk({tag, " read"}, dout, exp);
  endtask

  task automatic t_reset_state;
    chk("R1 ack after reset", 16'(ack), 16'h0);
    chk("R1 dout after reset", dout, 16'h0);
    rd_reg(16'h2003, 16'h0000, "R1 lane unlocked");
  endtask

  task automatic t_scratch;
    wr_reg(16'h0010, 16'hA5A5, "R3");
    wr_reg(16'h0017, 16'h1234, "R4");
    wr_reg(16'h0013, 16'hFFFF, "R4");
    rd_reg(16'h0010, 16'hA5A5, "R3 entry0");
    rd_reg(16'h0017, 16'h1234, "R4 entry7");
    rd_reg(16'h0013, 16'hFFFF, "R4 entry3");
    wr_reg(16'h0010, 16'h0001, "R3 overwrite");
    rd_reg(16'h0010, 16'h0001, "R3 overwrite");
  endtask

  task automatic t_unimpl;
    wr_reg(16'h0018, 16'hBEEF, "R5");
    rd_reg(16'h0018, 16'h0000, "R5 undecoded");
    rd_reg(16'h0000, 16'h0000, "R5 zero addr");
    rd_reg(16'h0010, 16'h0001, "R5 no alias");
  endtask

  task automatic t_clkrst_plain;
    wr_reg(16'h7F3F, 16'h00F0, "R6");
    rd_reg(16'h7F3F, 16'h00F0, "R6 readback");
    wr_reg(16'h2003, 16'hFFFF, "R9 ro");
    rd_reg(16'h2003, 16'h0000, "R9 write ignored");
  endtask

  task automatic t_internal_reset;
    rd_reg(16'h0013, 16'hFFFF, "R10 preload dout");
    strobe(SA, 16'h7F3F, 1'b1, "R7");
    strobe(SD, 16'h0001, 1'b1, "R7");
    strobe(SW, 16'h0000, 1'b0, "R7 no ack");
    chk("R10 dout cleared", dout, 16'h0);
    strobe(SA, 16'h0017, 1'b0, "R8 ignored");
    idle(15);
    strobe(SR, 16'h0000, 1'b1, "R7 responsive");
    chk("R8 capture ignored", dout, 16'h0);
    rd_reg(16'h2003, 16'h0000, "R9 locking");
    idle(LOCKC);
    rd_reg(16'h2003, 16'h0002, "R9 locked");
    rd_reg(16'h7F3F, 16'h0000, "R10 clkrst cleared");
    rd_reg(16'h0017, 16'h1234, "R10 scratch kept");
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    t_reset_state;
    t_scratch;
    t_unimpl;
    t_clkrst_plain;
    t_internal_reset;
    idle(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule